// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

This block is the operand-fetch stage of a small accumulator machine. Every instruction it accepts is two memory words long. The first word holds the opcode, and the second holds an address field. After a start strobe the unit reads the opcode word through a single-port synchronous memory port. It takes the addressing mode from the low four bits of that word and, when the mode needs it, reads the address field from the next word. It then forms the effective address, makes up to two further memory reads (one for indirection, one for the operand), and applies any update to the general register R1 that the mode calls for.

When it finishes, the unit presents the effective address, the operand that is to load the accumulator, the updated program counter and the updated R1, and it pulses a done flag for one cycle. Eleven mode codes are legal: implied plus ten modes that form an address. The remaining codes raise an illegal flag. The surrounding pipeline supplies the PC, R1, the index register and the base register, and it writes the results back itself.

Top module: `opf_unit`

## Requirements
- R1: Memory reads are issued one at a time. Each read is a one-cycle pulse of `mem_re` with `mem_addr`, and `mem_rdata` is valid in the second cycle after the pulse. The opcode word is read at PC. Every legal mode except implied also reads the address field at PC+1 and returns `pc_out` = PC+2.
- R2: The mode is bits [3:0] of the opcode word, and bits above it are ignored. The codes are: 0 implied, 1 immediate, 2 direct, 3 indirect, 4 PC-relative, 5 indexed, 6 base, 7 register, 8 register-indirect, 9 auto-increment, 10 auto-decrement.
- R3: Implied mode (code 0) reads only the opcode word and returns `pc_out` = PC+1, `ea_out` = 0 and `operand_out` = 0.
- R4: Immediate mode (code 1) returns `ea_out` = PC+1 and `operand_out` = the address field, and makes no third read.
- R5: Direct mode (code 2) returns `ea_out` = the field and `operand_out` = mem[field].
- R6: Indirect mode (code 3) returns `ea_out` = mem[field] and `operand_out` = mem[mem[field]], using four reads in total.
- R7: PC-relative mode (code 4) returns `ea_out` = field + PC + 2, modulo 2^W, and the operand read from that address.
- R8: Indexed mode (code 5) uses `ea_out` = field + index register. Base mode (code 6) uses `ea_out` = field + base register. In both modes the operand is read from `ea_out`.
- R9: Register mode (code 7) returns `operand_out` = R1 and `ea_out` = 0, with no read after the field word.
- R10: Register-indirect mode (code 8) returns `ea_out` = R1 and the operand read from R1, and leaves R1 unchanged.
- R11: Auto-increment mode (code 9) uses the old R1 as `ea_out` and returns `r1_out` = R1+1.
- R12: Auto-decrement mode (code 10) returns `r1_out` = R1-1 and uses that new value as `ea_out`.
- R13: Codes 11 to 15 finish after the opcode read with `illegal` = 1, `pc_out` = PC, `r1_out` = R1 and `ea_out` = `operand_out` = 0. `illegal` is 0 for legal codes.
- R14: `done` is a one-cycle pulse on the 2n-th rising edge after the edge that samples `start`, where n is the number of reads. The result outputs hold until the next pulse. `start` is ignored while an instruction is in progress and is accepted in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin fetching the instruction at `pc_in` |
| pc_in | input | W | Address of the opcode word |
| r1_in | input | W | General register R1 |
| idx_in | input | W | Index register |
| base_in | input | W | Base register |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | W | Memory read address |
| mem_rdata | input | W | Memory read data, valid two cycles after the strobe |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Mode code was not legal |
| ea_out | output | W | Effective address |
| operand_out | output | W | Operand for the accumulator |
| pc_out | output | W | Updated PC |
| r1_out | output | W | Updated R1 |

## Verification
The completion of one instruction and the acceptance of the next can fall in the same cycle. The bench provokes this by raising `start` on the falling edge at which it sees `done`, for every pair of consecutive instructions. It then judges the overlap against a behavioural model that checks `done` on every clock, as well as the address of every read and the results of each mode. The bench also raises a second `start` while an indirect fetch is in progress, with different register values, and confirms that neither the read addresses nor the results change.

// File: rtl/opf_pkg.sv
package opf_pkg;

  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MD_IMPLIED  = 4'd0;
  localparam logic [MODE_W-1:0] MD_IMM      = 4'd1;
  localparam logic [MODE_W-1:0] MD_DIRECT   = 4'd2;
  localparam logic [MODE_W-1:0] MD_INDIRECT = 4'd3;
  localparam logic [MODE_W-1:0] MD_REL      = 4'd4;
  localparam logic [MODE_W-1:0] MD_INDEX    = 4'd5;
  localparam logic [MODE_W-1:0] MD_BASE     = 4'd6;
  localparam logic [MODE_W-1:0] MD_REG      = 4'd7;
  localparam logic [MODE_W-1:0] MD_REGIND   = 4'd8;
  localparam logic [MODE_W-1:0] MD_AUTOINC  = 4'd9;
  localparam logic [MODE_W-1:0] MD_AUTODEC  = 4'd10;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_CAP} fetch_state_t;
  typedef enum logic [1:0] {PH_OPC, PH_FLD, PH_IND, PH_OPR} fetch_phase_t;

  typedef struct packed {
    logic legal;     // code is one of the defined modes
    logic one_word;  // only the opcode word is consumed
    logic no_read;   // result known once the field word arrives
    logic indirect;  // one extra read before the operand read
  } mode_info_t;

endpackage

// File: rtl/opf_decode.sv
module opf_decode
  import opf_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output mode_info_t        info
);

  always_comb begin
    info = '0;
    info.legal = 1'b1;
    case (mode)
      MD_IMPLIED:  info.one_word = 1'b1;
      MD_IMM,
      MD_REG:      info.no_read  = 1'b1;
      MD_INDIRECT: info.indirect = 1'b1;
      MD_DIRECT, MD_REL, MD_INDEX, MD_BASE,
      MD_REGIND, MD_AUTOINC, MD_AUTODEC: ;
      default:     info.legal    = 1'b0;
    endcase
  end

endmodule

// File: rtl/opf_ea_calc.sv
module opf_ea_calc
  import opf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [W-1:0]      field,
  input  logic [W-1:0]      pc,
  input  logic [W-1:0]      r1,
  input  logic [W-1:0]      idx,
  input  logic [W-1:0]      base,
  output logic [W-1:0]      ea,
  output logic [W-1:0]      op_now,
  output logic [W-1:0]      r1_new
);

  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  always_comb begin
    ea     = '0;
    op_now = '0;
    r1_new = r1;
    case (mode)
      MD_IMM: begin
        ea     = pc + ONE;
        op_now = field;
      end
      MD_DIRECT:  ea = field;
      MD_REL:     ea = field + pc + TWO;
      MD_INDEX:   ea = field + idx;
      MD_BASE:    ea = field + base;
      MD_REG:     op_now = r1;
      MD_REGIND:  ea = r1;
      MD_AUTOINC: begin
        ea     = r1;
        r1_new = r1 + ONE;
      end
      MD_AUTODEC: begin
        ea     = r1 - ONE;
        r1_new = r1 - ONE;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/opf_unit.sv
module opf_unit
  import opf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] pc_in,
  input  logic [W-1:0] r1_in,
  input  logic [W-1:0] idx_in,
  input  logic [W-1:0] base_in,
  output logic         mem_re,
  output logic [W-1:0] mem_addr,
  input  logic [W-1:0] mem_rdata,
  output logic         done,
  output logic         illegal,
  output logic [W-1:0] ea_out,
  output logic [W-1:0] operand_out,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] r1_out
);

  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  fetch_state_t      state;
  fetch_phase_t      phase;
  logic [MODE_W-1:0] mode_q;
  logic [W-1:0]      pc_q, r1_q, idx_q, base_q;
  logic [W-1:0]      ea_q, r1_fin_q;

  logic [MODE_W-1:0] dec_mode;
  mode_info_t        info;
  logic [W-1:0]      ea_c, op_c, r1_c;

  // Mode taken straight from the bus while the opcode word is on it
  assign dec_mode = (state == ST_CAP && phase == PH_OPC) ?
                    mem_rdata[MODE_W-1:0] : mode_q;

  opf_decode u_dec (
    .mode (dec_mode),
    .info (info)
  );

  opf_ea_calc #(.W(W)) u_ea (
    .mode   (mode_q),
    .field  (mem_rdata),
    .pc     (pc_q),
    .r1     (r1_q),
    .idx    (idx_q),
    .base   (base_q),
    .ea     (ea_c),
    .op_now (op_c),
    .r1_new (r1_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      phase       <= PH_OPC;
      mode_q      <= '0;
      pc_q        <= '0;
      r1_q        <= '0;
      idx_q       <= '0;
      base_q      <= '0;
      ea_q        <= '0;
      r1_fin_q    <= '0;
      mem_re      <= 1'b0;
      mem_addr    <= '0;
      done        <= 1'b0;
      illegal     <= 1'b0;
      ea_out      <= '0;
      operand_out <= '0;
      pc_out      <= '0;
      r1_out      <= '0;
    end else begin
      done   <= 1'b0;
      mem_re <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            pc_q     <= pc_in;
            r1_q     <= r1_in;
            idx_q    <= idx_in;
            base_q   <= base_in;
            mem_re   <= 1'b1;
            mem_addr <= pc_in;
            phase    <= PH_OPC;
            state    <= ST_REQ;
          end
        end
        ST_REQ: state <= ST_CAP;
        ST_CAP: begin
          case (phase)
            PH_OPC: begin
              mode_q <= dec_mode;
              if (!info.legal) begin
                done        <= 1'b1;
                illegal     <= 1'b1;
                ea_out      <= '0;
                operand_out <= '0;
                pc_out      <= pc_q;
                r1_out      <= r1_q;
                state       <= ST_IDLE;
              end else if (info.one_word) begin
                done        <= 1'b1;
                illegal     <= 1'b0;
                ea_out      <= '0;
                operand_out <= '0;
                pc_out      <= pc_q + ONE;
                r1_out      <= r1_q;
                state       <= ST_IDLE;
              end else begin
                mem_re   <= 1'b1;
                mem_addr <= pc_q + ONE;
                phase    <= PH_FLD;
                state    <= ST_REQ;
              end
            end
            PH_FLD: begin
              ea_q     <= ea_c;
              r1_fin_q <= r1_c;
              if (info.no_read) begin
                done        <= 1'b1;
                illegal     <= 1'b0;
                ea_out      <= ea_c;
                operand_out <= op_c;
                pc_out      <= pc_q + TWO;
                r1_out      <= r1_c;
                state       <= ST_IDLE;
              end else begin
                mem_re   <= 1'b1;
                mem_addr <= info.indirect ? mem_rdata : ea_c;
                phase    <= info.indirect ? PH_IND : PH_OPR;
                state    <= ST_REQ;
              end
            end
            PH_IND: begin
              ea_q     <= mem_rdata;
              mem_re   <= 1'b1;
              mem_addr <= mem_rdata;
              phase    <= PH_OPR;
              state    <= ST_REQ;
            end
            default: begin
              done        <= 1'b1;
              illegal     <= 1'b0;
              ea_out      <= ea_q;
              operand_out <= mem_rdata;
              pc_out      <= pc_q + TWO;
              r1_out      <= r1_fin_q;
              state       <= ST_IDLE;
            end
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Completion flag lasts exactly one cycle
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R14
  // Never more than one read in flight
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> !mem_re); // R1
  AST_NO_READ_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_re); // R14
  // Illegal codes leave the architectural registers untouched
  AST_ILLEGAL_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
    (done && illegal) |-> (pc_out == pc_q && r1_out == r1_q && ea_out == '0)); // R13
  AST_TWO_WORD_PC: assert property (@(posedge clk) disable iff (rst)
    (done && !illegal && mode_q != MD_IMPLIED) |-> pc_out == pc_q + TWO); // R1
  AST_AUTOINC_POST: assert property (@(posedge clk) disable iff (rst)
    (done && !illegal && mode_q == MD_AUTOINC) |-> (r1_out == r1_q + ONE && ea_out == r1_q)); // R11
  AST_AUTODEC_PRE: assert property (@(posedge clk) disable iff (rst)
    (done && !illegal && mode_q == MD_AUTODEC) |-> (r1_out == r1_q - ONE && ea_out == r1_out)); // R12
  AST_IMPLIED_ONE_WORD: assert property (@(posedge clk) disable iff (rst)
    (done && !illegal && mode_q == MD_IMPLIED) |-> pc_out == pc_q + ONE); // R3

endmodule

// File: tb/opf_unit_tb.sv
module opf_unit_tb_top;

  localparam int W = 16;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 1024;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [W-1:0] pc_in, r1_in, idx_in, base_in;
  logic         mem_re;
  logic [W-1:0] mem_addr;
  logic [W-1:0] mem_rdata;
  logic         done, illegal;
  logic [W-1:0] ea_out, operand_out, pc_out, r1_out;

  logic [W-1:0] mem [0:DEPTH-1];

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opf_unit #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .pc_in(pc_in), .r1_in(r1_in), .idx_in(idx_in), .base_in(base_in),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .illegal(illegal), .ea_out(ea_out),
    .operand_out(operand_out), .pc_out(pc_out), .r1_out(r1_out)
  );

  // Synchronous single-port memory, one cycle of read latency
  always_ff @(posedge clk)
    if (mem_re) mem_rdata <= mem[mem_addr[9:0]];

  function automatic logic [W-1:0] rd(input logic [W-1:0] a);
    return mem[a[9:0]];
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Runs one instruction from a falling edge; returns on the falling edge
  // where done is seen, so the next call overlaps start with done.
  task automatic exec(input string req, input logic [W-1:0] opw, input logic [W-1:0] pc,
                      input logic [W-1:0] r1, input logic [W-1:0] idx,
                      input logic [W-1:0] base, input bit poke_busy);
    int n;
    logic [W-1:0] fld, e_ea, e_op, e_pc, e_r1, e_ill;
    logic [W-1:0] e_addr [4];
    int rd_i;
    mem[pc[9:0]] = opw;
    fld = rd(pc + 16'd1);
    e_r1 = r1; e_ill = 0; e_ea = 0; e_op = 0; e_pc = pc + 16'd2;
    e_addr[0] = pc; e_addr[1] = pc + 16'd1; e_addr[2] = 0; e_addr[3] = 0;
    n = 3;
    case (int'(opw[3:0]))
      0: begin n = 1; e_pc = pc + 16'd1; end
      1: begin n = 2; e_ea = pc + 16'd1; e_op = fld; end
      2: e_ea = fld;
      3: begin n = 4; e_ea = rd(fld); e_addr[3] = e_ea; e_addr[2] = fld; end
      4: e_ea = fld + pc + 16'd2;
      5: e_ea = fld + idx;
      6: e_ea = fld + base;
      7: begin n = 2; e_op = r1; end
      8: e_ea = r1;
      9: begin e_ea = r1; e_r1 = r1 + 16'd1; end
      10: begin e_r1 = r1 - 16'd1; e_ea = e_r1; end
      default: begin n = 1; e_ill = 1; e_pc = pc; end
    endcase
    if (n == 3) e_addr[2] = e_ea;
    if (n >= 3) e_op = rd(e_ea);
    start = 1'b1; pc_in = pc; r1_in = r1; idx_in = idx; base_in = base;
    rd_i = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == 1) start = 1'b0;
      if (poke_busy && k == 2) begin
        start = 1'b1; pc_in = 16'd900; r1_in = 16'd11; idx_in = 16'd3; base_in = 16'd4;
      end
      if (poke_busy && k == 3) start = 1'b0;
      if (mem_re) begin
        if (rd_i < 4) chk({req, " R1 read addr"}, mem_addr, e_addr[rd_i]);
        rd_i++;
      end
      chk({req, " R14 done timing"}, W'(done), W'(k == 2*n+1));
      if (k == 2*n+1) begin
        chk({req, " R1 read count"}, W'(rd_i), W'(n));
        chk({req, " ea"}, ea_out, e_ea);
        chk({req, " operand"}, operand_out, e_op);
        chk({req, " pc"}, pc_out, e_pc);
        chk({req, " r1"}, r1_out, e_r1);
        chk({req, " R13 illegal flag"}, W'(illegal), e_ill);
        return;
      end
    end
    checks++; failures++;
    $display("FAIL %s R14 no done act=0 exp=1", req);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog R14 act=0 exp=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = W'(i * 7 + 3);
    // Worked example image
    mem[201] = 16'd500; mem[500] = 16'd800; mem[800] = 16'd300;
    mem[702] = 16'd325; mem[600] = 16'd900; mem[400] = 16'd700;
    mem[399] = 16'd450; mem[550] = 16'd1234;
    mem[301] = 16'd400;
    mem[1023] = 16'd5; mem[5] = 16'd77;
    rst = 1'b1; start = 1'b0;
    pc_in = '0; r1_in = '0; idx_in = '0; base_in = '0;
    repeat (3) @(negedge clk);
    // Reset state
    chk("reset done", W'(done), 0);
    chk("reset mem_re R1", W'(mem_re), 0);
    chk("reset illegal R13", W'(illegal), 0);
    chk("reset ea", ea_out, 0);
    rst = 1'b0;
    @(negedge clk);

    exec("R3 implied",        16'h0000, 200, 400, 100, 50, 0);
    exec("R4 immediate",      16'h0001, 200, 400, 100, 50, 0);
    exec("R5 direct",         16'h0002, 200, 400, 100, 50, 0);
    exec("R6 indirect",       16'h0003, 200, 400, 100, 50, 0);
    exec("R7 relative",       16'h0004, 200, 400, 100, 50, 0);
    exec("R8 indexed",        16'h0005, 200, 400, 100, 50, 0);
    exec("R8 base",           16'h0006, 200, 400, 100, 50, 0);
    exec("R9 register",       16'h0007, 200, 400, 100, 50, 0);
    exec("R10 reg indirect",  16'h0008, 200, 400, 100, 50, 0);
    exec("R11 autoinc",       16'h0009, 200, 400, 100, 50, 0);
    exec("R12 autodec",       16'h000A, 200, 400, 100, 50, 0);
    exec("R13 illegal 12",    16'h000C, 200, 400, 100, 50, 0);
    exec("R13 illegal 15",    16'h000F, 200, 400, 100, 50, 0);
    exec("R13 illegal 11",    16'h000B, 200, 400, 100, 50, 0);
    // Upper opcode bits ignored, start ignored while busy
    exec("R2 R14 indirect hi-bits busy", 16'hAB33, 200, 400, 100, 50, 1);
    exec("R2 direct hi-bits", 16'hFFF2, 200, 400, 100, 50, 0);
    // Second pattern
    exec("R5 direct p2",      16'h0002, 300, 200, 200, 7, 0);
    exec("R7 relative p2",    16'h0004, 300, 200, 200, 7, 0);
    exec("R8 indexed p2",     16'h0005, 300, 200, 200, 7, 0);
    exec("R10 reg indirect p2", 16'h0008, 300, 200, 200, 7, 0);
    // Wraparound boundaries
    exec("R7 relative wrap",  16'h0004, 16'hFFFE, 3, 0, 0, 0);
    exec("R12 autodec wrap",  16'h000A, 300, 0, 0, 0, 0);
    exec("R11 autoinc wrap",  16'h0009, 300, 16'hFFFF, 0, 0, 0);
    // Outputs hold after done
    repeat (3) @(negedge clk);
    chk("R14 hold r1", r1_out, 16'h0000);
    chk("R14 hold done low", W'(done), 0);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule